// File: doc/BRIEF.md
# Fractional Clock Enable Generator

This block turns a fast system clock into a slower pulse train whose average rate is any fixed-point fraction of the system rate. A phase accumulator adds a programmed step on every rising system-clock edge. Each time the running sum crosses one whole unit, the block lowers an active-low enable for one cycle and keeps only the fractional remainder, so the rounding error is carried into later cycles instead of being lost. The step is the ratio f_out / f_sys, so a divide by 20/3 uses a step of 0.15.

The enable drives a glitch-free gate. A register clocked on the falling edge samples the enable, and the gated clock passes the high phase of the system-clock cycle that follows each low enable. If the step is chosen as N times the reference frequency divided by the system frequency, the output is an N-times multiple of a reference clock, made without any oscillator. A single-cycle reference-edge pulse clears the accumulator, so the output phase starts again from each reference edge. Working out the step value is left to the surrounding logic.

Top module: `frac_clk_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the accumulator clears to 0 and `en_n` is 1 after that edge. `clk_out` stays low through the following low and high clock phases.
- R2: `incr` is unsigned fixed point with 17 bits. Bit 16 is the integer bit and bits 15:0 are the fraction, so one unit is 65536. While the accumulated sum after an edge stays below one unit, `en_n` stays 1.
- R3: When the sum reaches or exceeds one unit at an edge, `en_n` is 0 after that edge and the accumulator keeps the sum minus one unit. With a step of 9830 (about 0.15) starting from 0, the seventh edge is the first to drive `en_n` low.
- R4: Starting from a cleared accumulator with a constant step below one unit, the number of low `en_n` cycles over K edges equals floor(K * incr / 65536).
- R5: `clk_out` is high during the high phase of a system-clock cycle only when `en_n` was 0 after the previous rising edge. `clk_out` is low at all other times.
- R6: A high `ref_edge` at a rising edge clears the accumulator to 0 and leaves `en_n` at 1 after that edge. The next edge then accumulates from 0.
- R7: An `incr` of one unit or more is treated as exactly one unit, so `en_n` is 0 after every edge that has no `ref_edge`.
- R8: An `incr` of 0 keeps `en_n` at 1, so `clk_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the accumulator updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| incr | input | 17 | Phase step, 1 integer bit and 16 fraction bits |
| ref_edge | input | 1 | One-cycle pulse that clears the accumulator |
| en_n | output | 1 | Active-low enable, registered on the rising edge |
| clk_out | output | 1 | Gated copy of the system clock |

## Verification
A bad remainder in the accumulator shows at the ports as an `en_n` low cycle that comes one or more edges early or late compared with floor arithmetic on the step. The per-cycle scoreboard catches such a cycle on the edge it happens. A slow drift that a single-cycle compare could miss is caught by the pulse count over 200 edges after a reference clear. Errors in the falling-edge gate show on `clk_out` within half a cycle, because the bench samples every high phase against the previous cycle's expected enable.

// File: rtl/frac_clk_pkg.sv
// Shared definitions for the fractional clock enable generator.
// Assumes a 1-bit integer part is enough for the clamped step.
package frac_clk_pkg;

    // Default fixed-point split of the phase step
    parameter int unsigned INT_W_DEF  = 1;
    parameter int unsigned FRAC_W_DEF = 16;

    // Decision taken by the accumulator at each rising edge
    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_ACCUM = 2'd1,
        ACT_WRAP  = 2'd2
    } acc_action_e;

endpackage

// File: rtl/frac_incr_clamp.sv
// Converts the raw step into an effective step of FRAC_W+1 bits.
// Any set integer bit saturates the step to exactly one unit.
// Assumes INT_W >= 1.
module frac_incr_clamp #(
    parameter int unsigned INT_W  = 1,
    parameter int unsigned FRAC_W = 16
) (
    input  logic [INT_W+FRAC_W-1:0] incr,
    output logic [FRAC_W:0]         eff_step
);
    localparam int unsigned INC_W = INT_W + FRAC_W;
    localparam logic [FRAC_W:0] ONE_UNIT = {1'b1, {FRAC_W{1'b0}}};

    logic int_set;

    generate
        if (INT_W == 1) begin : g_single
            // integer part is one bit wide
            assign int_set = incr[INC_W-1];
        end else begin : g_multi
            // integer part has several bits; any of them saturates
            assign int_set = |incr[INC_W-1:FRAC_W];
        end
    endgenerate

    // choose the saturated or the fractional step
    always_comb begin
        if (int_set) begin
            eff_step = ONE_UNIT;
        end else begin
            eff_step = {1'b0, incr[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/frac_phase_accum.sv
// Phase accumulator with compare and subtract-one wrap.
// Holds only the fractional remainder; raises the enable low for one
// cycle on each wrap. Synchronous active-low reset; clear wins over step.
module frac_phase_accum
    import frac_clk_pkg::*;
#(
    parameter int unsigned FRAC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic [FRAC_W:0] eff_step,
    output logic            en_n
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;
    acc_action_e       action;

    // sum of remainder and step, one extra bit for the carry
    always_comb begin
        sum = {1'b0, acc_q} + eff_step;
    end

    // pick the action for this edge
    always_comb begin
        if (clear) begin
            action = ACT_CLEAR;
        end else if (sum[FRAC_W]) begin
            action = ACT_WRAP;
        end else begin
            action = ACT_ACCUM;
        end
    end

    // update remainder and enable on the rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            en_n  <= 1'b1;
        end else begin
            unique case (action)
                ACT_CLEAR: begin
                    acc_q <= '0;
                    en_n  <= 1'b1;
                end
                ACT_WRAP: begin
                    acc_q <= sum[FRAC_W-1:0];
                    en_n  <= 1'b0;
                end
                default: begin
                    acc_q <= sum[FRAC_W-1:0];
                    en_n  <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/frac_gate.sv
// Glitch-free gate: samples the active-low enable on the falling edge and
// ANDs the result with the clock. Assumes en_n changes only after rising edges.
module frac_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    output logic clk_out
);
    logic pass_q;

    // capture the enable while the clock is low
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
        end else begin
            pass_q <= ~en_n;
        end
    end

    // pass the high phase of the selected cycle
    assign clk_out = clk & pass_q;
endmodule

// File: rtl/frac_clk_gen.sv
// Top of the fractional clock enable generator.
// Step format: INT_W integer bits above FRAC_W fraction bits.
// Assumes ref_edge is already synchronous to clk.
module frac_clk_gen
    import frac_clk_pkg::*;
#(
    parameter int unsigned INT_W  = INT_W_DEF,
    parameter int unsigned FRAC_W = FRAC_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [INT_W+FRAC_W-1:0] incr,
    input  logic                    ref_edge,
    output logic                    en_n,
    output logic                    clk_out
);
    logic [FRAC_W:0] eff_step;

    frac_incr_clamp #(.INT_W(INT_W), .FRAC_W(FRAC_W)) clamp_i (
        .incr     (incr),
        .eff_step (eff_step)
    );

    frac_phase_accum #(.FRAC_W(FRAC_W)) accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ref_edge),
        .eff_step (eff_step),
        .en_n     (en_n)
    );

    frac_gate gate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_n    (en_n),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/frac_clk_gen_chk.sv
// Port-level checker for frac_clk_gen, attached by bind.
module frac_clk_gen_chk #(
    parameter int unsigned INT_W  = 1,
    parameter int unsigned FRAC_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [INT_W+FRAC_W-1:0] incr,
    input logic                    ref_edge,
    input logic                    en_n,
    input logic                    clk_out
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> en_n);

    // R6
    ref_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_edge |=> en_n);

    // R8
    zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (incr == '0) |=> en_n);

    // R7
    sat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((incr[INT_W+FRAC_W-1:FRAC_W] != '0) && !ref_edge) |=> !en_n);

    // R3
    wrap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_n |-> (($past(incr) != '0) && !$past(ref_edge)));
endmodule

bind frac_clk_gen frac_clk_gen_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .incr     (incr),
    .ref_edge (ref_edge),
    .en_n     (en_n),
    .clk_out  (clk_out)
);

// File: tb/frac_clk_gen_tb_top.sv
// Scoreboard bench: the driver predicts each cycle, the monitor compares.
module frac_clk_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT = 65536;

    typedef struct {
        logic  exp_en_n;
        logic  exp_clk_out;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] incr = '0;
    logic        ref_edge = 1'b0;
    logic        en_n;
    logic        clk_out;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    int m_acc = 0;
    logic m_en = 1'b1;
    int r4_lows = 0;

    frac_clk_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .incr     (incr),
        .ref_edge (ref_edge),
        .en_n     (en_n),
        .clk_out  (clk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // drive one cycle and push the prediction for the next rising edge
    task automatic step(input logic r, input logic [16:0] inc,
                        input logic rf, input string tag);
        item_t it;
        int eff;
        int sum;
        @(posedge clk);
        #3;
        rst_n = r; incr = inc; ref_edge = rf;
        it.exp_clk_out = r ? ~m_en : 1'b0;
        eff = inc[16] ? UNIT : int'(inc[15:0]);
        if (!r || rf) begin
            m_acc = 0; m_en = 1'b1;
        end else begin
            sum = m_acc + eff;
            if (sum >= UNIT) begin
                m_acc = sum - UNIT; m_en = 1'b0;
            end else begin
                m_acc = sum; m_en = 1'b1;
            end
        end
        it.exp_en_n = m_en;
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compare right after each rising edge, clock is high
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (en_n !== it.exp_en_n) begin
                    errors++;
                    $display("FAIL %s en_n actual %0b expected %0b", it.tag, en_n, it.exp_en_n);
                end
                checks++;
                if (clk_out !== it.exp_clk_out) begin
                    errors++;
                    $display("FAIL %s/R5 clk_out actual %0b expected %0b", it.tag, clk_out, it.exp_clk_out);
                end
                if (it.tag == "R4" && en_n === 1'b0) r4_lows++;
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // stimulus
    initial begin
        int exp_r4;
        for (int i = 0; i < 3; i++) step(1'b0, 17'h0, 1'b0, "R1");
        for (int i = 0; i < 20; i++) step(1'b1, 17'h0, 1'b0, "R8");
        step(1'b1, 17'd9830, 1'b1, "R6");
        for (int i = 0; i < 30; i++) step(1'b1, 17'd9830, 1'b0, "R3");
        step(1'b1, 17'd9830, 1'b1, "R6");
        for (int i = 0; i < 4; i++) step(1'b1, 17'd9830, 1'b0, "R6");
        step(1'b1, 17'd9830, 1'b1, "R6");
        for (int i = 0; i < 200; i++) step(1'b1, 17'd9830, 1'b0, "R4");
        step(1'b1, 17'h0100, 1'b1, "R6");
        for (int i = 0; i < 20; i++) step(1'b1, 17'h0100, 1'b0, "R2");
        for (int i = 0; i < 10; i++) step(1'b1, 17'hFFFF, 1'b0, "R3");
        for (int i = 0; i < 10; i++) step(1'b1, 17'h8000, 1'b0, "R5");
        for (int i = 0; i < 10; i++) step(1'b1, 17'h1FFFF, 1'b0, "R7");
        step(1'b1, 17'h10000, 1'b1, "R6");
        for (int i = 0; i < 10; i++) step(1'b1, 17'h10000, 1'b0, "R7");
        for (int i = 0; i < 3; i++) step(1'b0, 17'h10000, 1'b0, "R1");
        for (int i = 0; i < 3; i++) step(1'b1, 17'h0, 1'b0, "R8");
        repeat (3) @(posedge clk);
        #2;
        exp_r4 = (200 * 9830) / UNIT;
        checks++;
        if (r4_lows != exp_r4) begin
            errors++;
            $display("FAIL R4 low count actual %0d expected %0d", r4_lows, exp_r4);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule